// File: doc/BRIEF.md
# Randomized-Mapping Secure Cache

This block is a small data cache that breaks the link between an address and the physical line that holds it. Every physical line carries a line-number register that holds an index. That index is wider than the line count needs: it has n bits to select a line plus k extra bits. A lookup compares the index field of the address against every valid line-number register at once. That comparison gives an index hit or miss. The tag of the matching line is then compared, which gives a tag hit or miss. Data comes from the cache only when both comparisons hit.

On an index miss the line to replace is drawn at random from all physical lines. Its line-number register then takes the new index. An observer who watches which cached data disappears learns nothing about where the victim's address lives. On an index hit with a tag miss, the matching line is the one replaced, so no two valid lines ever hold the same index. A dirty victim is written to memory before the refill is requested.

Both the lookup side and the memory side are valid/ready streams. A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from acceptance until the response has been taken. A response, once raised, holds its value and flags until `rsp_ready` is seen high. A memory request holds its address, direction and data until `mem_req_ready` is seen high. A memory read is answered by a single-cycle `mem_rsp_valid` pulse.

Top module: `rmcache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0 and every line is invalid.
- R2: The low IDX_W = clog2(LINES)+EXTRA_K address bits form the index field and the remaining upper bits form the tag. `rsp_idx_hit` is 1 exactly when some valid line-number register equals the index field, so the first access after reset reports `rsp_idx_hit`=0.
- R3: `rsp_tag_hit` is 1 only when the index hits and the matched line's tag equals the address tag. A full hit causes no memory traffic. A read returns the line data, and a write response returns the written data.
- R4: A read returns the most recent value written to that address. This holds whether the value is still in the cache, was written back, or is original memory content.
- R5: On an index hit with a tag miss, the matched line is the one replaced. If it is dirty, its old address and data are written back.
- R6: On any miss, a dirty victim is written back (`mem_req_write`=1) before a single refill read (`mem_req_write`=0) of the requested address. A clean or invalid victim causes no write-back. A write miss allocates the line and marks it dirty.
- R7: On an index miss the victim is a 16-bit maximal-length LFSR value modulo LINES. The LFSR never holds zero and advances every cycle. Over 64 writes to 64 distinct index values that start from reset, the victims cover at least 12 of the 16 lines, which means between 48 and 52 write-backs.
- R8: No two valid lines ever hold equal line-number registers.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle after its response is accepted. It is never high while `rsp_valid` is high.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response data and both flags stay stable. While `mem_req_valid` is high and `mem_req_ready` is low, the memory request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_rdata | output | DATA_W | Read data, or written data for a write |
| rsp_idx_hit | output | 1 | Index field matched a line-number register |
| rsp_tag_hit | output | 1 | Matched line's tag also matched |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rsp_valid | input | 1 | Refill data valid, one cycle |
| mem_rsp_data | input | DATA_W | Refill data |

## Verification
Two events can fall in the same cycle here.

The first pair is a held-back response and the next request arriving. The bench holds `rsp_ready` low and keeps a second request valid. For several cycles it requires `req_ready` to stay low while the response data holds. It then releases the response and checks that the waiting request is served with correct data.

The second pair is a stalled memory port and the free-running LFSR. The victim is latched at lookup, so random `mem_req_ready` stalls during write-back and refill must not change which line is replaced. This is judged by the write-back addresses, by the write-back count over 64 distinct-index writes, and by every later read against a reference memory.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FREQ,
    ST_FWAIT,
    ST_RESP
  } rmc_state_t;
endpackage

// File: rtl/rmc_lfsr.sv
module rmc_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state
);
  localparam logic [15:0] START = (SEED == 16'h0) ? 16'h0001 : SEED;
  localparam logic [15:0] TAPS  = 16'hB400;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= START;
    else        state <= {1'b0, state[15:1]} ^ (state[0] ? TAPS : 16'h0);
  end
endmodule

// File: rtl/rmc_line_store.sv
module rmc_line_store #(
  parameter int LINES  = 16,
  parameter int LN_W   = 4,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [LINES-1:0]  match,
  output logic              idx_hit,
  output logic [LN_W-1:0]   hit_line,
  output logic              tag_hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic [LN_W-1:0]   rd_line,
  output logic              vic_valid,
  output logic              vic_dirty,
  output logic [IDX_W-1:0]  vic_idx,
  output logic [TAG_W-1:0]  vic_tag,
  output logic [DATA_W-1:0] vic_data,
  input  logic              wr_en,
  input  logic [LN_W-1:0]   wr_line,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [IDX_W-1:0]  idx_q  [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (idx_q[g] == lk_idx);
  end

  always_comb begin
    hit_line = '0;
    for (int i = 0; i < LINES; i++)
      if (match[i]) hit_line = hit_line | LN_W'(i);
  end

  assign idx_hit   = |match;
  assign tag_hit   = idx_hit && (tag_q[hit_line] == lk_tag);
  assign hit_data  = data_q[hit_line];
  assign vic_valid = valid_q[rd_line];
  assign vic_dirty = dirty_q[rd_line];
  assign vic_idx   = idx_q[rd_line];
  assign vic_tag   = tag_q[rd_line];
  assign vic_data  = data_q[rd_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_line] <= 1'b1;
      dirty_q[wr_line] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      idx_q[wr_line]  <= wr_idx;
      tag_q[wr_line]  <= wr_tag;
      data_q[wr_line] <= wr_data;
    end
  end
endmodule

// File: rtl/rmc_ctrl.sv
module rmc_ctrl
  import rmc_pkg::*;
#(
  parameter int LN_W   = 4,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_idx_hit,
  output logic              rsp_tag_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [LN_W-1:0]   rnd_line,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              idx_hit,
  input  logic [LN_W-1:0]   hit_line,
  input  logic              tag_hit,
  input  logic [DATA_W-1:0] hit_data,
  output logic [LN_W-1:0]   rd_line,
  input  logic              vic_valid,
  input  logic              vic_dirty,
  input  logic [IDX_W-1:0]  vic_idx,
  input  logic [TAG_W-1:0]  vic_tag,
  input  logic [DATA_W-1:0] vic_data,
  output logic              st_we,
  output logic [LN_W-1:0]   st_line,
  output logic [DATA_W-1:0] st_data,
  output logic              st_dirty
);
  rmc_state_t        state, nxt;
  logic              wr_q, ih_q, th_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rsp_q;
  logic [LN_W-1:0]   vic_q, vic_sel;

  assign lk_idx      = addr_q[IDX_W-1:0];
  assign lk_tag      = addr_q[ADDR_W-1:IDX_W];
  assign rsp_rdata   = rsp_q;
  assign rsp_idx_hit = ih_q;
  assign rsp_tag_hit = th_q;

  always_comb begin
    req_ready     = (state == ST_IDLE);
    rsp_valid     = (state == ST_RESP);
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = addr_q;
    mem_req_wdata = vic_data;
    vic_sel       = idx_hit ? hit_line : rnd_line;
    rd_line       = (state == ST_LOOK) ? vic_sel : vic_q;
    st_we         = 1'b0;
    st_line       = vic_q;
    st_data       = wr_q ? wdata_q : mem_rsp_data;
    st_dirty      = wr_q;
    nxt           = state;
    unique case (state)
      ST_IDLE:  if (req_valid) nxt = ST_LOOK;
      ST_LOOK: begin
        if (tag_hit) begin
          nxt = ST_RESP;
          if (wr_q) begin
            st_we   = 1'b1;
            st_line = hit_line;
          end
        end else begin
          nxt = (vic_valid && vic_dirty) ? ST_WB : ST_FREQ;
        end
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {vic_tag, vic_idx};
        if (mem_req_ready) nxt = ST_FREQ;
      end
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) nxt = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (mem_rsp_valid) begin
          st_we = 1'b1;
          nxt   = ST_RESP;
        end
      end
      ST_RESP:  if (rsp_ready) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wr_q    <= 1'b0;
      ih_q    <= 1'b0;
      th_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
      vic_q   <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && req_valid) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (state == ST_LOOK) begin
        ih_q  <= idx_hit;
        th_q  <= tag_hit;
        vic_q <= vic_sel;
        rsp_q <= wr_q ? wdata_q : hit_data;
      end
      if (state == ST_FWAIT && mem_rsp_valid) rsp_q <= st_data;
    end
  end
endmodule

// File: rtl/rmcache.sv
module rmcache #(
  parameter int          LINES   = 16,
  parameter int          EXTRA_K = 2,
  parameter int          ADDR_W  = 10,
  parameter int          DATA_W  = 32,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_idx_hit,
  output logic              rsp_tag_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int LN_W  = $clog2(LINES);
  localparam int IDX_W = LN_W + EXTRA_K;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [15:0]       lfsr_val;
  logic [LN_W-1:0]   rnd_line;
  logic [LINES-1:0]  match_vec;
  logic [IDX_W-1:0]  lk_idx, vic_idx;
  logic [TAG_W-1:0]  lk_tag, vic_tag;
  logic              idx_hit, tag_hit, vic_valid, vic_dirty, st_we, st_dirty;
  logic [LN_W-1:0]   hit_line, rd_line, st_line;
  logic [DATA_W-1:0] hit_data, vic_data, st_data;

  assign rnd_line = LN_W'(lfsr_val % 16'(LINES));

  rmc_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_val));

  rmc_line_store #(
    .LINES(LINES), .LN_W(LN_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .match(match_vec), .idx_hit(idx_hit), .hit_line(hit_line),
    .tag_hit(tag_hit), .hit_data(hit_data), .rd_line(rd_line),
    .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_idx(vic_idx),
    .vic_tag(vic_tag), .vic_data(vic_data), .wr_en(st_we),
    .wr_line(st_line), .wr_idx(lk_idx), .wr_tag(lk_tag),
    .wr_data(st_data), .wr_dirty(st_dirty)
  );

  rmc_ctrl #(
    .LN_W(LN_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_idx_hit(rsp_idx_hit), .rsp_tag_hit(rsp_tag_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rnd_line(rnd_line),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .idx_hit(idx_hit),
    .hit_line(hit_line), .tag_hit(tag_hit), .hit_data(hit_data),
    .rd_line(rd_line), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_idx(vic_idx), .vic_tag(vic_tag), .vic_data(vic_data),
    .st_we(st_we), .st_line(st_line), .st_data(st_data), .st_dirty(st_dirty)
  );
endmodule

// File: rtl/rmc_chk.sv
module rmc_chk #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_idx_hit,
  input logic              rsp_tag_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [LINES-1:0]  match_vec,
  input logic [15:0]       lfsr_val
);
  AST_RDY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) &&
    $stable(rsp_idx_hit) && $stable(rsp_tag_hit)); // R10
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write) &&
    $stable(mem_req_addr) && $stable(mem_req_wdata)); // R10
  AST_TAG_NEEDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_tag_hit |-> rsp_idx_hit); // R3
  AST_IDX_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R8
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_val != 16'h0); // R7
endmodule

bind rmcache rmc_chk #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_idx_hit(rsp_idx_hit), .rsp_tag_hit(rsp_tag_hit),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .match_vec(match_vec), .lfsr_val(lfsr_val)
);

// File: tb/tb_rmcache.sv
`timescale 1ns/1ps
module tb_rmcache;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_idx_hit, rsp_tag_hit;
  logic [DW-1:0] rsp_rdata;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, mem_rsp_data = '0;

  always #10 clk = ~clk;

  rmcache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_idx_hit(rsp_idx_hit), .rsp_tag_hit(rsp_tag_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  logic [DW-1:0] bmem [1024];
  logic [DW-1:0] refm [1024];
  int total = 0, bad = 0;
  int n_wr = 0, n_rd = 0, wb_total = 0;
  bit wb_first = 0, rd_pend = 0, done = 0;
  int rd_wait = 0;
  logic [AW-1:0] rd_addr, last_wb_addr, last_rd_addr;
  logic [DW-1:0] last_wb_data;
  logic [DW-1:0] r_data;
  logic r_ih, r_th;

  function automatic logic [DW-1:0] init_val(int a);
    return 32'h5A17_0000 ^ (a * 32'h0001_0F1F);
  endfunction

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model with random back-pressure
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (rd_pend) begin
        if (rd_wait == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = bmem[rd_addr];
          rd_pend = 0;
        end else rd_wait--;
      end
      mem_req_ready = ($urandom_range(0, 3) != 0);
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          bmem[mem_req_addr] = mem_req_wdata;
          if (n_wr == 0 && n_rd == 0) wb_first = 1;
          n_wr++; wb_total++;
          last_wb_addr = mem_req_addr;
          last_wb_data = mem_req_wdata;
        end else begin
          rd_pend = 1;
          rd_addr = mem_req_addr;
          rd_wait = $urandom_range(0, 2);
          n_rd++;
          last_rd_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic send_req(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    n_wr = 0; n_rd = 0; wb_first = 0;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic get_rsp();
    forever begin
      rsp_ready = $urandom_range(0, 1);
      if (rsp_valid && rsp_ready) begin
        r_data = rsp_rdata; r_ih = rsp_idx_hit; r_th = rsp_tag_hit;
        @(negedge clk);
        rsp_ready = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_req(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    send_req(w, a, d);
    get_rsp();
    if (w) refm[a] = d;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 1024; i++) refm[i] = bmem[i];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] held;
    int wb0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) begin bmem[i] = init_val(i); refm[i] = bmem[i]; end
    do_reset();
    @(negedge clk);
    check(req_ready == 1, "R1 req_ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    check(mem_req_valid == 0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 0);

    // first access: index miss, clean (invalid) victim, refill only
    do_req(0, 10'h005, '0);
    check(r_ih == 0 && r_th == 0, "R2 first access index miss", {r_ih, r_th}, 0);
    check(n_wr == 0 && n_rd == 1, "R6 invalid victim no write-back", 32'(n_wr), 0);
    check(last_rd_addr == 10'h005, "R6 refill address", 32'(last_rd_addr), 32'h005);
    check(r_data == refm[10'h005], "R4 refill data", r_data, refm[10'h005]);

    do_req(0, 10'h005, '0);
    check(r_ih && r_th, "R3 repeat read full hit", {r_ih, r_th}, 3);
    check(n_wr + n_rd == 0, "R3 full hit no memory traffic", 32'(n_wr + n_rd), 0);

    do_req(1, 10'h005, 32'hDEAD_0005);
    check(r_th && n_rd == 0 && r_data == 32'hDEAD_0005, "R3 write hit returns written data",
          r_data, 32'hDEAD_0005);
    do_req(0, 10'h005, '0);
    check(r_data == 32'hDEAD_0005, "R4 read after write", r_data, 32'hDEAD_0005);

    // same index field 0x05, tag 1: matched dirty line replaced
    do_req(0, 10'h045, '0);
    check(r_ih == 1 && r_th == 0, "R5 index hit tag miss flags", {r_ih, r_th}, 2);
    check(n_wr == 1 && last_wb_addr == 10'h005, "R5 write-back of matched line",
          32'(last_wb_addr), 32'h005);
    check(last_wb_data == 32'hDEAD_0005, "R5 write-back data", last_wb_data, 32'hDEAD_0005);
    check(wb_first && n_rd == 1, "R6 write-back before refill", 32'(wb_first), 1);
    check(r_data == refm[10'h045], "R4 replaced line data", r_data, refm[10'h045]);

    do_req(0, 10'h005, '0);
    check(r_ih == 1 && r_th == 0, "R5 old tag now misses", {r_ih, r_th}, 2);
    check(n_wr == 0, "R6 clean victim no write-back", 32'(n_wr), 0);
    check(r_data == 32'hDEAD_0005, "R4 data from written-back memory", r_data, 32'hDEAD_0005);

    do_req(0, 10'h006, '0);
    check(r_ih == 0, "R2 unused index misses", 32'(r_ih), 0);

    // response held back while the next request waits
    send_req(0, 10'h006, '0);
    req_valid = 1; req_write = 1; req_addr = 10'h007; req_wdata = 32'hBEEF_0007;
    rsp_ready = 0;
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(req_ready == 0, "R9 no accept while response pending", 32'(req_ready), 0);
      check(rsp_valid && rsp_rdata == held, "R10 response held", rsp_rdata, held);
    end
    check(held == refm[10'h006], "R4 stalled read data", held, refm[10'h006]);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    n_wr = 0; n_rd = 0; wb_first = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    get_rsp();
    refm[10'h007] = 32'hBEEF_0007;
    check(r_data == 32'hBEEF_0007, "R9 waiting request served", r_data, 32'hBEEF_0007);
    do_req(0, 10'h007, '0);
    check(r_th && r_data == 32'hBEEF_0007, "R6 write miss allocates", r_data, 32'hBEEF_0007);

    // victim spread: 64 distinct-index writes from reset
    do_reset();
    wb0 = wb_total;
    for (int j = 0; j < 64; j++) begin
      do_req(1, AW'(j), 32'hC000_0000 | j);
      check(r_ih == 0, "R7 distinct index misses", 32'(r_ih), 0);
    end
    check(wb_total - wb0 >= 48 && wb_total - wb0 <= 52, "R7 victims spread over lines",
          32'(wb_total - wb0), 48);
    for (int j = 0; j < 64; j++) begin
      do_req(0, AW'(j), '0);
      check(r_data == refm[j], "R8 unique mapping read-back", r_data, refm[j]);
    end

    // random mix against reference memory
    for (int i = 0; i < 500; i++) begin
      logic [AW-1:0] a;
      bit w;
      logic [DW-1:0] d;
      a = {2'b00, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 63))};
      w = $urandom_range(0, 1);
      d = $urandom;
      do_req(w, a, d);
      if (!w) check(r_data == refm[a], "R4 random read", r_data, refm[a]);
      check(!r_th || r_ih, "R3 tag hit implies index hit", {r_ih, r_th}, 3);
      if (r_th) check(n_wr + n_rd == 0, "R3 hit silent", 32'(n_wr + n_rd), 0);
      else begin
        check(n_rd == 1 && last_rd_addr == a, "R6 single refill", 32'(last_rd_addr), 32'(a));
        if (n_wr != 0) check(wb_first && n_wr == 1, "R6 write-back first", 32'(n_wr), 1);
      end
    end
    finish_run();
  end
endmodule